// File: doc/BRIEF.md
# SPI Serial Memory Command Interface

This block is the serial front end of a 16K x 8 byte memory. It acts as an SPI slave in clock modes 0 and 3, oversampling the serial pins with a faster system clock. Each selection carries an 8-bit command code, then a 16-bit address for array accesses, then data. The block turns these into single-cycle requests to the neighbouring array and register logic: per-byte read fetches, per-byte write strobes with a final commit or abort, write-enable and write-disable pulses, and a status-register write.

The block streams read data and status bytes back on the serial output and keeps that output disabled when nothing is being driven. A pause input suspends a transfer in the middle of a byte. While the neighbouring logic reports a self-timed write in progress, only the status read is honoured. Page buffering and protection decisions belong to other blocks. The array port is assumed to return `rd_data` on the cycle after `rd_req`.

Top module: `spi_mem_cmd_if`

## Requirements
- R1: Only the command codes 0x06 (write enable), 0x04 (write disable), 0x05 (status read), 0x01 (status write), 0x03 (array read) and 0x02 (array write) are acted upon. Any other first byte makes the rest of the selection produce no request, no strobe and no enabled output.
- R2: Serial input is taken on rising SCK and serial output changes on falling SCK, most significant bit first, in both mode 0 (SCK idle low) and mode 3 (SCK idle high).
- R3: While chip select is high, `spi_miso_oe` is low. Every selection starts afresh at the falling edge of chip select, and all end-of-command actions happen at its rising edge.
- R4: The 16-bit address is sent high byte first, and only its low 14 bits select a location. Bits 15:14 are ignored.
- R5: An array read returns the byte at the address, then the bytes at successively higher addresses, wrapping from 0x3FFF to 0x0000 for as long as chip select stays low. Each byte is fetched with a one-cycle `rd_req`, and `rd_data` is taken on the following cycle.
- R6: The pause input takes effect only when it changes while SCK is low. While paused, `spi_miso_oe` is low and SCK and data-input transitions are ignored, so the transfer resumes where it stopped.
- R7: If `busy_i` is high when the command byte completes, every code except 0x05 is ignored.
- R8: `wren_stb` or `wrdi_stb` pulses only when chip select rises after exactly 8 clocked bits.
- R9: Each received write data byte pulses `wr_byte_stb` with its address. Within a selection, addresses advance in bits 5:0 only, wrapping inside the 64-byte page. At chip-select rise, `wr_commit` pulses if at least one whole byte arrived and no partial byte follows; otherwise `wr_abort` pulses.
- R10: A status write pulses `sr_wr_stb` with the first data byte when chip select rises on a byte boundary after at least one data byte. Otherwise nothing is written.
- R11: A status read returns the value of `status_i`, sampled afresh for each byte, for as long as chip select stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Pause input, active low |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for the serial data out pad |
| busy_i | input | 1 | Internal write cycle in progress |
| status_i | input | 8 | Status register value to be returned |
| rd_req | output | 1 | Array byte fetch request |
| rd_addr | output | 14 | Array fetch address |
| rd_data | input | 8 | Array byte, valid the cycle after rd_req |
| wr_byte_stb | output | 1 | One write data byte received |
| wr_addr | output | 14 | Address of that byte |
| wr_data | output | 8 | The byte |
| wr_commit | output | 1 | Write sequence ended correctly |
| wr_abort | output | 1 | Write sequence discarded |
| wren_stb | output | 1 | Write-enable command |
| wrdi_stb | output | 1 | Write-disable command |
| sr_wr_stb | output | 1 | Status write command |
| sr_wr_data | output | 8 | Status byte to write |

## Verification
The assertions assume that SCK stays at each level for at least four system clocks. They also assume that chip select and the pause input change only while SCK is steady, so each synchronized edge is seen once and the returned array byte is in place before the next falling edge. The stimulus holds each SCK level for eight system clocks. It moves chip select only with SCK at its idle level, and it changes the pause input only while SCK is low. The only toggling of SCK during a pause is the deliberate toggling that R6 says must be ignored.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [3:0] {
    ST_OPC, ST_WEN, ST_WDI, ST_RDSR, ST_WRSR,
    ST_AHI, ST_ALO, ST_RDAT, ST_WDAT, ST_SKIP
  } seq_st_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int              NPIN    = 4,
  parameter logic [NPIN-1:0] RST_VAL = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pins_i,
  output logic [NPIN-1:0] pins_o
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[i];
        sync_q <= RST_VAL[i];
      end else begin
        meta_q <= pins_i[i];
        sync_q <= meta_q;
      end
    end
    assign pins_o[i] = sync_q;
  end
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          arm,
  input  logic          fall_ev,
  input  logic [DW-1:0] src,
  output logic          miso,
  output logic          tx_on,
  output logic          take
);
  localparam int CW = $clog2(DW);

  logic [DW-2:0] sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          on_q, on_d, out_q, out_d;

  assign take = fall_ev & arm & ~clr & (cnt_q == '0);

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    on_d  = on_q;
    out_d = out_q;
    if (clr) begin
      cnt_d = '0;
      on_d  = 1'b0;
    end else if (fall_ev && arm) begin
      on_d = 1'b1;
      if (cnt_q == '0) begin
        out_d = src[DW-1];
        sh_d  = src[DW-2:0];
      end else begin
        out_d = sh_q[DW-2];
        sh_d  = {sh_q[DW-3:0], 1'b0};
      end
      cnt_d = (cnt_q == CW'(DW-1)) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      on_q  <= 1'b0;
      out_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      on_q  <= on_d;
      out_q <= out_d;
    end
  end

  assign miso  = out_q;
  assign tx_on = on_q;

  // R2: every accepted falling edge moves the bit position by one
  assert_bit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_ev && arm && !clr) |=> (on_q && cnt_q == CW'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_mem_pkg::*;
#(
  parameter int AW = 14,
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_ev,
  input  logic          cs_go,
  input  logic          cs_end,
  input  logic          mosi_s,
  input  logic          busy_i,
  input  logic [7:0]    status_i,
  input  logic          byte_take,
  input  logic [7:0]    rd_data,
  output logic          tx_arm,
  output logic [7:0]    tx_src,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic          wr_byte_stb,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          wr_commit,
  output logic          wr_abort,
  output logic          wren_stb,
  output logic          wrdi_stb,
  output logic          sr_wr_stb,
  output logic [7:0]    sr_wr_data
);
  localparam int HW = AW - 8;

  seq_st_t       st_q, st_d;
  logic [6:0]    sr_q, sr_d;
  logic [2:0]    bits_q, bits_d;
  logic [HW-1:0] ahi_q, ahi_d;
  logic          rdop_q, rdop_d, got_q, got_d, cap_q, cap_d, arm_q, arm_d;
  logic [AW-1:0] ptr_q, ptr_d, wad_q, wad_d, rda_q, rda_d, wao_q, wao_d;
  logic [7:0]    src_q, src_d, wdo_q, wdo_d, sdat_q, sdat_d;
  logic          rreq_q, rreq_d, wstb_q, wstb_d, cmt_q, cmt_d, abt_q, abt_d;
  logic          wen_q, wen_d, wdi_q, wdi_d, srw_q, srw_d;
  logic [7:0]    byte_w;
  logic [PW-1:0] wlow;
  logic [AW-1:0] addr_w;

  assign byte_w = {sr_q, mosi_s};
  assign wlow   = wad_q[PW-1:0] + 1'b1;
  assign addr_w = {ahi_q, byte_w};

  always_comb begin
    st_d = st_q;   sr_d = sr_q;   bits_d = bits_q; ahi_d = ahi_q;
    rdop_d = rdop_q; got_d = got_q; arm_d = arm_q; ptr_d = ptr_q;
    wad_d = wad_q; rda_d = rda_q; wao_d = wao_q; wdo_d = wdo_q;
    sdat_d = sdat_q; src_d = src_q; cap_d = rreq_q;
    rreq_d = 1'b0; wstb_d = 1'b0; cmt_d = 1'b0; abt_d = 1'b0;
    wen_d = 1'b0;  wdi_d = 1'b0;  srw_d = 1'b0;
    if (cap_q)           src_d = rd_data;
    if (st_q == ST_RDSR) src_d = status_i;
    if (cs_go || cs_end) begin
      if (cs_end) begin
        case (st_q)
          ST_WEN:  wen_d = (bits_q == 3'd0);
          ST_WDI:  wdi_d = (bits_q == 3'd0);
          ST_WRSR: srw_d = got_q && (bits_q == 3'd0);
          ST_WDAT: begin
            cmt_d = got_q && (bits_q == 3'd0);
            abt_d = !(got_q && (bits_q == 3'd0));
          end
          ST_AHI, ST_ALO: abt_d = !rdop_q;
          default: ;
        endcase
      end
      st_d = ST_OPC; bits_d = 3'd0; got_d = 1'b0; arm_d = 1'b0;
    end else begin
      if (rise_ev) begin
        sr_d   = byte_w[6:0];
        bits_d = bits_q + 3'd1;
        if (st_q == ST_WEN || st_q == ST_WDI) begin
          st_d = ST_SKIP;
        end else if (bits_q == 3'd7) begin
          case (st_q)
            ST_OPC: begin
              if (busy_i && byte_w != OP_RDSR) st_d = ST_SKIP;
              else begin
                case (byte_w)
                  OP_WREN:  st_d = ST_WEN;
                  OP_WRDI:  st_d = ST_WDI;
                  OP_RDSR:  begin st_d = ST_RDSR; arm_d = 1'b1; end
                  OP_WRSR:  st_d = ST_WRSR;
                  OP_READ:  begin st_d = ST_AHI; rdop_d = 1'b1; end
                  OP_WRITE: begin st_d = ST_AHI; rdop_d = 1'b0; end
                  default:  st_d = ST_SKIP;
                endcase
              end
            end
            ST_AHI: begin ahi_d = byte_w[HW-1:0]; st_d = ST_ALO; end
            ST_ALO: begin
              if (rdop_q) begin
                rreq_d = 1'b1; rda_d = addr_w; ptr_d = addr_w + 1'b1;
                arm_d = 1'b1; st_d = ST_RDAT;
              end else begin
                wad_d = addr_w; st_d = ST_WDAT;
              end
            end
            ST_WDAT: begin
              wstb_d = 1'b1; wao_d = wad_q; wdo_d = byte_w;
              wad_d = {wad_q[AW-1:PW], wlow}; got_d = 1'b1;
            end
            ST_WRSR: begin
              if (!got_q) sdat_d = byte_w;
              got_d = 1'b1;
            end
            default: ;
          endcase
        end
      end
      if (byte_take && st_q == ST_RDAT) begin
        rreq_d = 1'b1; rda_d = ptr_q; ptr_d = ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_OPC; sr_q <= '0; bits_q <= '0; ahi_q <= '0;
      rdop_q <= 1'b0; got_q <= 1'b0; arm_q <= 1'b0; cap_q <= 1'b0;
      ptr_q <= '0; wad_q <= '0; rda_q <= '0; wao_q <= '0;
      wdo_q <= '0; sdat_q <= '0; src_q <= '0;
      rreq_q <= 1'b0; wstb_q <= 1'b0; cmt_q <= 1'b0; abt_q <= 1'b0;
      wen_q <= 1'b0; wdi_q <= 1'b0; srw_q <= 1'b0;
    end else begin
      st_q <= st_d; sr_q <= sr_d; bits_q <= bits_d; ahi_q <= ahi_d;
      rdop_q <= rdop_d; got_q <= got_d; arm_q <= arm_d; cap_q <= cap_d;
      ptr_q <= ptr_d; wad_q <= wad_d; rda_q <= rda_d; wao_q <= wao_d;
      wdo_q <= wdo_d; sdat_q <= sdat_d; src_q <= src_d;
      rreq_q <= rreq_d; wstb_q <= wstb_d; cmt_q <= cmt_d; abt_q <= abt_d;
      wen_q <= wen_d; wdi_q <= wdi_d; srw_q <= srw_d;
    end
  end

  assign tx_arm = arm_q;       assign tx_src = src_q;
  assign rd_req = rreq_q;      assign rd_addr = rda_q;
  assign wr_byte_stb = wstb_q; assign wr_addr = wao_q;  assign wr_data = wdo_q;
  assign wr_commit = cmt_q;    assign wr_abort = abt_q;
  assign wren_stb = wen_q;     assign wrdi_stb = wdi_q;
  assign sr_wr_stb = srw_q;    assign sr_wr_data = sdat_q;

  // R8, R9, R10: at most one end-of-command pulse per cycle
  assert_one_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wen_q, wdi_q, srw_q, cmt_q, abt_q}));
  // R6: without an accepted clock or select edge, the bit count holds
  assert_bits_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_ev && !cs_go && !cs_end) |=> $stable(bits_q));
  // R5: a fetch follows the address byte or a byte handed to the shifter
  assert_fetch_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rreq_q |-> ($past(byte_take) || $past(st_q) == ST_ALO));
endmodule

// File: rtl/spi_mem_cmd_if.sv
module spi_mem_cmd_if #(
  parameter int AW = 14,
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sck,
  input  logic          spi_cs_n,
  input  logic          spi_mosi,
  input  logic          spi_hold_n,
  output logic          spi_miso,
  output logic          spi_miso_oe,
  input  logic          busy_i,
  input  logic [7:0]    status_i,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          wr_byte_stb,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          wr_commit,
  output logic          wr_abort,
  output logic          wren_stb,
  output logic          wrdi_stb,
  output logic          sr_wr_stb,
  output logic [7:0]    sr_wr_data
);
  localparam int NPIN = 4;

  logic [NPIN-1:0] pin_raw, pin_s;
  logic sck_s, csn_s, mosi_s, holdn_s;
  logic sck_d, csn_d, hold_q, hold_d;
  logic rise_ev, fall_ev, cs_go, cs_end, clr;
  logic tx_arm, tx_on, take;
  logic [7:0] tx_src;

  assign pin_raw = {spi_hold_n, spi_mosi, spi_cs_n, spi_sck};

  spi_pin_sync #(.NPIN(NPIN), .RST_VAL(4'b1010)) u_sync (
    .clk(clk), .rst_n(rst_n), .pins_i(pin_raw), .pins_o(pin_s));

  assign {holdn_s, mosi_s, csn_s, sck_s} = pin_s;

  always_comb begin
    hold_d = hold_q;
    if (csn_s)       hold_d = 1'b0;
    else if (!sck_s) hold_d = !holdn_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d  <= 1'b0;
      csn_d  <= 1'b1;
      hold_q <= 1'b0;
    end else begin
      sck_d  <= sck_s;
      csn_d  <= csn_s;
      hold_q <= hold_d;
    end
  end

  assign rise_ev = sck_s & ~sck_d & ~csn_s & ~hold_q;
  assign fall_ev = ~sck_s & sck_d & ~csn_s & ~hold_q;
  assign cs_go   = ~csn_s & csn_d;
  assign cs_end  = csn_s & ~csn_d;
  assign clr     = cs_go | cs_end;

  spi_cmd_seq #(.AW(AW), .PW(PW)) u_seq (
    .clk(clk), .rst_n(rst_n), .rise_ev(rise_ev), .cs_go(cs_go),
    .cs_end(cs_end), .mosi_s(mosi_s), .busy_i(busy_i), .status_i(status_i),
    .byte_take(take), .rd_data(rd_data), .tx_arm(tx_arm), .tx_src(tx_src),
    .rd_req(rd_req), .rd_addr(rd_addr), .wr_byte_stb(wr_byte_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit),
    .wr_abort(wr_abort), .wren_stb(wren_stb), .wrdi_stb(wrdi_stb),
    .sr_wr_stb(sr_wr_stb), .sr_wr_data(sr_wr_data));

  spi_tx_shift #(.DW(8)) u_tx (
    .clk(clk), .rst_n(rst_n), .clr(clr), .arm(tx_arm), .fall_ev(fall_ev),
    .src(tx_src), .miso(spi_miso), .tx_on(tx_on), .take(take));

  assign spi_miso_oe = tx_on & ~hold_q & ~csn_s;

  // R3: once deselection has settled, the shifter is idle
  assert_idle_deselect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (csn_s && csn_d) |-> !tx_on);
  // R6: the pause state only changes while SCK is low
  assert_hold_low_sck_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_s && !csn_s) |=> (hold_q == $past(hold_q) || csn_s));
endmodule

// File: tb/spi_mem_cmd_if_bench.sv
`timescale 1ns/1ps
module spi_mem_cmd_if_bench;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0, spi_hold_n = 1'b1;
  logic busy_i = 1'b0;
  logic [7:0] status_i = 8'h00, rd_data = 8'h00;
  logic spi_miso, spi_miso_oe, rd_req, wr_byte_stb, wr_commit, wr_abort;
  logic wren_stb, wrdi_stb, sr_wr_stb;
  logic [13:0] rd_addr, wr_addr;
  logic [7:0] wr_data, sr_wr_data;

  int errs = 0, nchk = 0;
  int n_cmt = 0, n_abt = 0, n_wen = 0, n_wdi = 0, n_srw = 0, cs_hi = 0, oe_bad = 0;
  logic [7:0] last_sr = 8'h00;
  logic oe_seen = 1'b0;
  logic [21:0] wq[$];
  logic [7:0] tx_q[$];
  logic [7:0] rx_q[$];
  int hold_at = -1;

  always #2.5 clk = ~clk;

  spi_mem_cmd_if u_spi_mem_cmd_if (.*);

  function automatic logic [7:0] mem_f(input logic [13:0] a);
    return a[7:0] ^ {a[13:8], 2'b01};
  endfunction

  always @(posedge clk) if (rd_req) rd_data <= mem_f(rd_addr);

  always @(negedge clk) begin
    if (wr_byte_stb) wq.push_back({wr_addr, wr_data});
    if (wr_commit) n_cmt++;
    if (wr_abort)  n_abt++;
    if (wren_stb)  n_wen++;
    if (wrdi_stb)  n_wdi++;
    if (sr_wr_stb) begin n_srw++; last_sr = sr_wr_data; end
    if (spi_miso_oe) oe_seen = 1'b1;
    cs_hi = spi_cs_n ? cs_hi + 1 : 0;
    if (cs_hi > 4 && spi_miso_oe) oe_bad++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_hold();
    spi_hold_n = 1'b0;
    repeat (6) @(negedge clk);
    check(spi_miso_oe == 1'b0, "R6 output off during pause", spi_miso_oe, 0);
    spi_sck = 1'b1; spi_mosi = ~spi_mosi;
    repeat (4) @(negedge clk);
    spi_sck = 1'b0; spi_mosi = ~spi_mosi;
    repeat (4) @(negedge clk);
    spi_hold_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic frame(input int nbits, input bit m3);
    logic [7:0] rxb = 8'h00;
    rx_q.delete();
    oe_seen = 1'b0;
    while (tx_q.size() * 8 < nbits + 8) tx_q.push_back(8'h00);
    spi_sck = m3;
    repeat (H) @(negedge clk);
    spi_cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      if (!m3 && i == hold_at) do_hold();
      if (m3) spi_sck = 1'b0;
      spi_mosi = tx_q[i / 8][7 - (i % 8)];
      repeat (H) @(negedge clk);
      rxb = {rxb[6:0], spi_miso};
      spi_sck = 1'b1;
      if (i % 8 == 7) rx_q.push_back(rxb);
      repeat (H) @(negedge clk);
      if (!m3) spi_sck = 1'b0;
    end
    repeat (H) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (3 * H) @(negedge clk);
    tx_q.delete();
    hold_at = -1;
  endtask

  task automatic check_read(input logic [15:0] a, input int n, input bit m3, input string req);
    logic [13:0] b = a[13:0];
    tx_q = '{8'h03, a[15:8], a[7:0]};
    frame(24 + 8 * n, m3);
    for (int k = 0; k < n; k++)
      check(rx_q[3 + k] == mem_f(14'(b + k)), req, rx_q[3 + k], mem_f(14'(b + k)));
  endtask

  initial begin
    int c0, c1;
    logic [21:0] e;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(spi_miso_oe == 1'b0, "R3 reset output off", spi_miso_oe, 0);
    check(rd_req == 1'b0 && wr_byte_stb == 1'b0, "R3 reset no request", rd_req, 0);

    // R4 R2: mode 0 read, upper address bits ignored
    check_read(16'hC123, 4, 1'b0, "R4 read mode0");
    // R5 R2: mode 3 read across the top of the array
    check_read(16'h3FFE, 4, 1'b1, "R5 read wrap mode3");
    // R6: pause in the middle of the second data byte
    hold_at = 24 + 11;
    check_read(16'h0200, 3, 1'b0, "R6 read through pause");

    // R11: status read repeats
    status_i = 8'hA5;
    tx_q = '{8'h05};
    frame(24, 1'b0);
    check(rx_q[1] == 8'hA5 && rx_q[2] == 8'hA5, "R11 status read", rx_q[2], 8'hA5);

    // R8: exact write enable / disable, and an overlong one
    c0 = n_wen; tx_q = '{8'h06}; frame(8, 1'b0);
    check(n_wen == c0 + 1, "R8 write enable", n_wen - c0, 1);
    c0 = n_wen; tx_q = '{8'h06}; frame(9, 1'b1);
    check(n_wen == c0, "R8 enable with extra bit", n_wen - c0, 0);
    c0 = n_wdi; tx_q = '{8'h04}; frame(8, 1'b1);
    check(n_wdi == c0 + 1, "R8 write disable", n_wdi - c0, 1);

    // R9: page write wrapping inside the page, high address bits dropped
    wq.delete(); c0 = n_cmt;
    tx_q = '{8'h02, 8'h7F, 8'h7E, 8'h11, 8'h22, 8'h33};
    frame(48, 1'b0);
    check(n_cmt == c0 + 1, "R9 commit", n_cmt - c0, 1);
    check(wq.size() == 3, "R9 byte count", wq.size(), 3);
    if (wq.size() == 3) begin
      e = {14'h3F7E, 8'h11}; check(wq[0] == e, "R9 byte0", wq[0], e);
      e = {14'h3F7F, 8'h22}; check(wq[1] == e, "R9 byte1", wq[1], e);
      e = {14'h3F40, 8'h33}; check(wq[2] == e, "R9 page wrap", wq[2], e);
    end
    // R9: partial trailing byte and missing data
    wq.delete(); c0 = n_cmt; c1 = n_abt;
    tx_q = '{8'h02, 8'h00, 8'h10, 8'h44};
    frame(35, 1'b0);
    check(n_cmt == c0 && n_abt == c1 + 1, "R9 partial abort", n_abt - c1, 1);
    check(wq.size() == 1, "R9 whole byte seen", wq.size(), 1);
    c1 = n_abt; tx_q = '{8'h02, 8'h00, 8'h10};
    frame(24, 1'b1);
    check(n_abt == c1 + 1 && n_cmt == c0, "R9 no data abort", n_abt - c1, 1);

    // R10: status write, whole and partial
    c0 = n_srw; tx_q = '{8'h01, 8'h8C}; frame(16, 1'b0);
    check(n_srw == c0 + 1 && last_sr == 8'h8C, "R10 status write", last_sr, 8'h8C);
    c0 = n_srw; tx_q = '{8'h01, 8'hF0}; frame(12, 1'b0);
    check(n_srw == c0, "R10 partial status write", n_srw - c0, 0);

    // R1: unknown code, no output and no requests
    wq.delete(); c0 = n_wen + n_wdi + n_srw + n_cmt + n_abt;
    tx_q = '{8'h9F, 8'h06, 8'h02}; frame(24, 1'b0);
    check(oe_seen == 1'b0, "R1 output stays off", oe_seen, 0);
    check(wq.size() == 0 && (n_wen + n_wdi + n_srw + n_cmt + n_abt) == c0,
          "R1 no strobes", wq.size(), 0);

    // R7: busy blocks all but status read
    busy_i = 1'b1;
    c0 = n_wen; tx_q = '{8'h06}; frame(8, 1'b0);
    check(n_wen == c0, "R7 enable ignored busy", n_wen - c0, 0);
    wq.delete(); c1 = n_abt;
    tx_q = '{8'h02, 8'h00, 8'h00, 8'h55}; frame(32, 1'b0);
    check(wq.size() == 0 && n_abt == c1, "R7 write ignored busy", wq.size(), 0);
    status_i = 8'h3C;
    tx_q = '{8'h05}; frame(16, 1'b1);
    check(rx_q[1] == 8'h3C, "R7 status read while busy", rx_q[1], 8'h3C);
    busy_i = 1'b0;

    check(oe_bad == 0, "R3 output off while deselected", oe_bad, 0);

    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++; nchk++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule